// File: doc/BRIEF.md
# Triggered Repeating ADC Scan Sequencer

This block controls a successive-approximation converter core in a hardware-triggered, continuously repeating four-channel scan. Software controls it through an enable level, writes to a start/busy bit and writes to a group-select register. A hardware trigger pulse arms the scan. The block then walks the four channels of the selected group in order. For each channel it issues a start pulse, a channel index and a conversion tag. When the matching done strobe returns, it latches the result and raises one interrupt pulse. After the fourth channel it wraps to the first and keeps going.

A conversion in flight can be cut short in four ways. A fresh trigger, any group-select write or a write of 1 to the busy bit discards the partial conversion and restarts the scan at the group's first slot. Clearing the busy bit discards the conversion and drops back to trigger standby. Every abort moves the conversion tag on. A done strobe that belongs to a cancelled conversion therefore never reaches the result register or the interrupt. The converter core is outside this block and must echo the tag it was given.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, and after the enable level is raised from the stopped state, busy is 0 and no conversion start is issued until a hardware trigger arrives.
- R2: While enable is 0 the block is stopped: trigger pulses are ignored, and one cycle after enable is sampled low busy reads 0 and any running conversion is dropped without a result. Enable low outranks every other input.
- R3: A trigger sampled in standby sets busy to 1 on the next cycle, with a start pulse in that same cycle on the group's first channel.
- R4: Channels are converted in slot order 0,1,2,3. The channel index is the group number in the upper bits and the slot in the two low bits, so group 0 covers channels 0 to 3 and group 1 covers channels 4 to 7.
- R5: Each accepted done strobe updates result and result channel and gives a one-cycle interrupt pulse in the following cycle. The start for the next slot is issued in that same cycle.
- R6: After slot 3 completes, the scan continues with slot 0 of the same group without further stimulus.
- R7: A trigger while busy discards the running conversion, giving no result and no interrupt, and restarts at slot 0.
- R8: A group-select write while busy discards the running conversion and restarts at slot 0 of the newly written group. A group write while not busy only stores the group and starts nothing.
- R9: Writing 1 to the busy bit while busy discards the running conversion and restarts at slot 0.
- R10: Writing 0 to the busy bit while busy discards the running conversion, clears busy on the next cycle and returns to standby, where a new trigger is needed. Clearing outranks restart requests in the same cycle.
- R11: A done strobe is accepted only while busy, only after the current start has been issued, and only when its tag equals the current conversion tag. Any other done strobe is ignored.
- R12: Writing 1 to the busy bit in standby has no effect: busy stays 0 and no start is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Converter enable level |
| hw_trig | input | 1 | Hardware trigger pulse |
| busy_wr | input | 1 | Write strobe for the start/busy bit |
| busy_wdata | input | 1 | Value written to the start/busy bit |
| grp_wr | input | 1 | Write strobe for the group-select register |
| grp_wdata | input | GRP_W | Group number written |
| conv_done | input | 1 | Done strobe from the converter core |
| conv_done_tag | input | TAG_W | Tag echoed with the done strobe |
| conv_result | input | RES_W | Conversion result from the core |
| busy | output | 1 | Start/busy bit readback |
| conv_start | output | 1 | One-cycle start pulse to the core |
| conv_ch | output | GRP_W+2 | Channel index for the conversion |
| conv_tag | output | TAG_W | Tag of the conversion being run |
| result | output | RES_W | Last accepted result |
| result_ch | output | GRP_W+2 | Channel of the last accepted result |
| eoc_irq | output | 1 | End-of-conversion interrupt pulse |

## Verification
On every cycle the embedded properties check several rules: the block stays idle and issues no start after enable goes low, starts are issued only while busy, every abort restarts at slot 0 with a start pending or returns to standby, no interrupt follows an abort cycle, and interrupts are single-cycle pulses. The channel order, the wrap after slot 3, the switch to a new group, and the proof that stale done strobes from aborted conversions never reach the result register all depend on long runs with a converter model in the loop. Only the bench scenarios show these, comparing each interrupt against a queue of expected channels and the value of the latest start.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int SLOTS      = 4;
    localparam int SLOT_W     = $clog2(SLOTS);
    localparam int DEF_GRP_W  = 1;
    localparam int DEF_RES_W  = 10;
    localparam int DEF_TAG_W  = 3;

    typedef enum logic [1:0] {
        SEQ_STOP = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic halt;
        logic restart;
        logic take;
    } seq_evt_t;

    function automatic logic [SLOT_W-1:0] slot_next(input logic [SLOT_W-1:0] s);
        return (s == SLOT_W'(SLOTS - 1)) ? '0 : s + SLOT_W'(1);
    endfunction

endpackage

// File: rtl/adc_scan_grp_reg.sv
module adc_scan_grp_reg #(
    parameter int GRP_W = adc_scan_pkg::DEF_GRP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             grp_wr,
    input  logic [GRP_W-1:0] grp_wdata,
    output logic [GRP_W-1:0] grp_q
);

    always_ff @(posedge clk) begin
        if (rst)         grp_q <= '0;
        else if (grp_wr) grp_q <= grp_wdata;
    end

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int TAG_W = DEF_TAG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic              hw_trig,
    input  logic              busy_wr,
    input  logic              busy_wdata,
    input  logic              grp_wr,
    input  logic              conv_done,
    input  logic [TAG_W-1:0]  conv_done_tag,
    output logic              busy,
    output logic              launch,
    output logic [SLOT_W-1:0] slot,
    output logic [TAG_W-1:0]  tag,
    output logic              take
);

    seq_state_e        state_q;
    logic [SLOT_W-1:0] slot_q;
    logic [TAG_W-1:0]  tag_q;
    logic              launch_q;
    logic              in_run;
    seq_evt_t          evt;

    always_comb begin
        in_run      = (state_q == SEQ_RUN);
        evt.halt    = cfg_en && in_run && busy_wr && !busy_wdata;
        evt.restart = cfg_en && in_run && !evt.halt &&
                      (hw_trig || grp_wr || (busy_wr && busy_wdata));
        evt.take    = cfg_en && in_run && !evt.halt && !evt.restart &&
                      !launch_q && conv_done && (conv_done_tag == tag_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SEQ_STOP;
            slot_q   <= '0;
            tag_q    <= '0;
            launch_q <= 1'b0;
        end else if (!cfg_en) begin
            state_q  <= SEQ_STOP;
            launch_q <= 1'b0;
            if (in_run) tag_q <= tag_q + TAG_W'(1);
        end else begin
            unique case (state_q)
                SEQ_STOP: state_q <= SEQ_WAIT;
                SEQ_WAIT: begin
                    if (hw_trig) begin
                        state_q  <= SEQ_RUN;
                        slot_q   <= '0;
                        launch_q <= 1'b1;
                        tag_q    <= tag_q + TAG_W'(1);
                    end
                end
                SEQ_RUN: begin
                    if (evt.halt) begin
                        state_q  <= SEQ_WAIT;
                        launch_q <= 1'b0;
                        tag_q    <= tag_q + TAG_W'(1);
                    end else if (evt.restart) begin
                        slot_q   <= '0;
                        launch_q <= 1'b1;
                        tag_q    <= tag_q + TAG_W'(1);
                    end else if (evt.take) begin
                        slot_q   <= slot_next(slot_q);
                        launch_q <= 1'b1;
                    end else begin
                        launch_q <= 1'b0;
                    end
                end
                default: state_q <= SEQ_STOP;
            endcase
        end
    end

    assign busy   = in_run;
    assign launch = launch_q;
    assign slot   = slot_q;
    assign tag    = tag_q;
    assign take   = evt.take;

    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_en) |-> (state_q == SEQ_STOP && !launch_q)); // R2

    AST_START_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        launch_q |-> (state_q == SEQ_RUN)); // R3

    AST_RESTART_FIRST: assert property (@(posedge clk) disable iff (rst)
        $past(evt.restart) |-> (launch_q && slot_q == '0)); // R7

    AST_HALT_WAIT: assert property (@(posedge clk) disable iff (rst)
        $past(evt.halt) |-> (state_q == SEQ_WAIT && !launch_q)); // R10

endmodule

// File: rtl/adc_scan_result.sv
module adc_scan_result #(
    parameter int RES_W = adc_scan_pkg::DEF_RES_W,
    parameter int CH_W  = adc_scan_pkg::DEF_GRP_W + adc_scan_pkg::SLOT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [CH_W-1:0]  ch_in,
    input  logic [RES_W-1:0] data_in,
    output logic [RES_W-1:0] result,
    output logic [CH_W-1:0]  result_ch,
    output logic             eoc_irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            result    <= '0;
            result_ch <= '0;
            eoc_irq   <= 1'b0;
        end else begin
            eoc_irq <= take;
            if (take) begin
                result    <= data_in;
                result_ch <= ch_in;
            end
        end
    end

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        eoc_irq |=> !eoc_irq); // R5

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int GRP_W = DEF_GRP_W,
    parameter int RES_W = DEF_RES_W,
    parameter int TAG_W = DEF_TAG_W,
    localparam int CH_W = GRP_W + SLOT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             hw_trig,
    input  logic             busy_wr,
    input  logic             busy_wdata,
    input  logic             grp_wr,
    input  logic [GRP_W-1:0] grp_wdata,
    input  logic             conv_done,
    input  logic [TAG_W-1:0] conv_done_tag,
    input  logic [RES_W-1:0] conv_result,
    output logic             busy,
    output logic             conv_start,
    output logic [CH_W-1:0]  conv_ch,
    output logic [TAG_W-1:0] conv_tag,
    output logic [RES_W-1:0] result,
    output logic [CH_W-1:0]  result_ch,
    output logic             eoc_irq
);

    logic [GRP_W-1:0]  grp_q;
    logic [SLOT_W-1:0] slot;
    logic              take;

    adc_scan_grp_reg #(.GRP_W(GRP_W)) u_grp (
        .clk       (clk),
        .rst       (rst),
        .grp_wr    (grp_wr),
        .grp_wdata (grp_wdata),
        .grp_q     (grp_q)
    );

    adc_scan_ctrl #(.TAG_W(TAG_W)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .cfg_en        (cfg_en),
        .hw_trig       (hw_trig),
        .busy_wr       (busy_wr),
        .busy_wdata    (busy_wdata),
        .grp_wr        (grp_wr),
        .conv_done     (conv_done),
        .conv_done_tag (conv_done_tag),
        .busy          (busy),
        .launch        (conv_start),
        .slot          (slot),
        .tag           (conv_tag),
        .take          (take)
    );

    assign conv_ch = {grp_q, slot};

    adc_scan_result #(.RES_W(RES_W), .CH_W(CH_W)) u_res (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .ch_in     (conv_ch),
        .data_in   (conv_result),
        .result    (result),
        .result_ch (result_ch),
        .eoc_irq   (eoc_irq)
    );

    AST_ABORT_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        $past(busy && cfg_en && (hw_trig || grp_wr || busy_wr)) |-> !eoc_irq); // R7

endmodule

// File: tb/sim_adc_scan_seq.sv
`timescale 1ns/1ps
module sim_adc_scan_seq;
    import adc_scan_pkg::*;

    localparam int GRP_W = 1;
    localparam int RES_W = 10;
    localparam int TAG_W = 3;
    localparam int CH_W  = GRP_W + SLOT_W;
    localparam int LAT   = 5;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst = 1'b1;
    logic             cfg_en = 1'b0, hw_trig = 1'b0, busy_wr = 1'b0, busy_wdata = 1'b0;
    logic             grp_wr = 1'b0;
    logic [GRP_W-1:0] grp_wdata = '0;
    logic             conv_done = 1'b0;
    logic [TAG_W-1:0] conv_done_tag = '0;
    logic [RES_W-1:0] conv_result = '0;
    logic             busy, conv_start, eoc_irq;
    logic [CH_W-1:0]  conv_ch, result_ch;
    logic [TAG_W-1:0] conv_tag;
    logic [RES_W-1:0] result;

    adc_scan_seq #(.GRP_W(GRP_W), .RES_W(RES_W), .TAG_W(TAG_W)) u0 (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .hw_trig(hw_trig),
        .busy_wr(busy_wr), .busy_wdata(busy_wdata), .grp_wr(grp_wr),
        .grp_wdata(grp_wdata), .conv_done(conv_done), .conv_done_tag(conv_done_tag),
        .conv_result(conv_result), .busy(busy), .conv_start(conv_start),
        .conv_ch(conv_ch), .conv_tag(conv_tag), .result(result),
        .result_ch(result_ch), .eoc_irq(eoc_irq)
    );

    int checks = 0;
    int fails  = 0;
    int exp_q[$];
    int exp_ch;
    int start_cnt = 0;
    int irq_cnt = 0;
    logic [RES_W-1:0] last_val = '0;
    logic             pv[LAT];
    logic [TAG_W-1:0] pt[LAT];
    logic [RES_W-1:0] pd[LAT];

    initial begin
        for (int i = 0; i < LAT; i++) begin
            pv[i] = 1'b0; pt[i] = '0; pd[i] = '0;
        end
    end

    // Monitor (scoreboard pop) followed by the fixed-latency converter model.
    always @(negedge clk) begin
        if (!rst && eoc_irq) begin
            irq_cnt++;
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R11 unexpected interrupt: actual ch=%0d expected none", result_ch);
            end else begin
                exp_ch = exp_q.pop_front();
                if (result_ch !== CH_W'(exp_ch)) begin
                    fails++;
                    $display("FAIL R4 result channel: actual %0d expected %0d", result_ch, exp_ch);
                end
                checks++;
                if (result !== last_val) begin
                    fails++;
                    $display("FAIL R11 result value: actual %0d expected %0d", result, last_val);
                end
            end
        end
        for (int i = LAT - 1; i > 0; i--) begin
            pv[i] = pv[i-1]; pt[i] = pt[i-1]; pd[i] = pd[i-1];
        end
        pv[0] = conv_start && !rst;
        pt[0] = conv_tag;
        pd[0] = RES_W'(start_cnt * 7 + int'(conv_ch) * 3 + 1);
        if (pv[0]) begin
            last_val = pd[0];
            start_cnt++;
        end
        conv_done     = pv[LAT-1];
        conv_done_tag = pt[LAT-1];
        conv_result   = pd[LAT-1];
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_trig();
        hw_trig = 1'b1; @(negedge clk); hw_trig = 1'b0;
    endtask

    task automatic write_busy(input logic v);
        busy_wr = 1'b1; busy_wdata = v; @(negedge clk); busy_wr = 1'b0; busy_wdata = 1'b0;
    endtask

    task automatic write_grp(input logic [GRP_W-1:0] g);
        grp_wr = 1'b1; grp_wdata = g; @(negedge clk); grp_wr = 1'b0;
    endtask

    task automatic push_group_seq(input int grp, input int first, input int n);
        for (int k = 0; k < n; k++) exp_q.push_back(grp * SLOTS + ((first + k) % SLOTS));
    endtask

    task automatic drain(input string req);
        int n = 0;
        while (exp_q.size() != 0 && n < 400) begin
            @(negedge clk); #1; n++;
        end
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    initial begin
        int s0, i0;
        tick(3);
        rst = 1'b0;
        tick(1);
        check(busy == 1'b0, "R1 reset busy", busy, 0);
        check(conv_start == 1'b0 && eoc_irq == 1'b0, "R1 reset outputs", conv_start, 0);

        // R2: trigger while disabled is ignored
        pulse_trig();
        tick(20);
        check(busy == 1'b0 && start_cnt == 0, "R2 trigger ignored when disabled", start_cnt, 0);

        // R1: enable gives standby without conversion
        cfg_en = 1'b1;
        tick(4);
        check(busy == 1'b0 && start_cnt == 0, "R1 standby after enable", start_cnt, 0);

        // R12: busy write 1 in standby has no effect
        write_busy(1'b1);
        tick(10);
        check(busy == 1'b0 && start_cnt == 0, "R12 busy write in standby ignored", start_cnt, 0);

        // R3/R4/R5/R6: trigger starts repeating scan of group 0
        push_group_seq(0, 0, 6);
        pulse_trig();
        check(busy == 1'b1, "R3 busy after trigger", busy, 1);
        check(conv_start == 1'b1 && conv_ch == '0, "R3 first start on slot 0", conv_ch, 0);
        drain("R6 scan wraps and continues");
        check(irq_cnt == 6, "R5 one interrupt per channel", irq_cnt, 6);

        // R7: trigger mid-conversion restarts at slot 0
        pulse_trig();
        push_group_seq(0, 0, 3);
        drain("R7 trigger restart");

        // R8: group write mid-conversion restarts on the new group
        write_grp(1'b1);
        push_group_seq(1, 0, 5);
        drain("R8 group write restart");

        // R9: busy write 1 mid-conversion restarts
        write_busy(1'b1);
        push_group_seq(1, 0, 2);
        drain("R9 busy rewrite restart");

        // R10: busy clear mid-conversion returns to standby
        write_busy(1'b0);
        check(busy == 1'b0, "R10 busy cleared", busy, 0);
        i0 = irq_cnt;
        tick(20);
        check(irq_cnt == i0 && busy == 1'b0, "R10/R11 no result after clear", irq_cnt, i0);
        push_group_seq(1, 0, 2);
        pulse_trig();
        drain("R10 new trigger required");

        // R8: group write while not busy only stores the group
        write_busy(1'b0);
        s0 = start_cnt;
        write_grp(1'b0);
        tick(10);
        check(busy == 1'b0 && start_cnt == s0, "R8 idle group write starts nothing", start_cnt, s0);
        push_group_seq(0, 0, 4);
        pulse_trig();
        check(conv_ch == '0, "R8 stored group used", conv_ch, 0);
        drain("R8 scan of stored group");

        // R2: enable low while running stops and ignores triggers
        cfg_en = 1'b0;
        tick(1);
        check(busy == 1'b0, "R2 busy drops with enable", busy, 0);
        i0 = irq_cnt;
        s0 = start_cnt;
        pulse_trig();
        tick(20);
        check(irq_cnt == i0 && start_cnt == s0 && busy == 1'b0, "R2 stopped and trigger ignored", start_cnt, s0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule